// File: doc/BRIEF.md
# Frame Conversion Command Queue

This block is the software-facing front end of a frame-conversion engine. Software writes parameter words, one after another, to a single command port. The block gathers every four words into one command: the luma source address, the two chroma source addresses, and the destination address. Each complete command covers exactly one frame. It enters a two-slot queue. The block presents the oldest queued command to the engine and waits for a valid/ready handshake. It allows only one frame in flight at a time.

When the engine reports that the frame in flight has finished, a sticky end-status flag is raised. Software can poll the flag or take the interrupt. The interrupt is the flag masked by an enable. A strobe clears the flag (write-one-to-clear). A word written while both slots hold commands is dropped and raises a sticky overflow flag. Dropping the master enable discards the partly written command and the whole queue, and clears the overflow flag.

Top module: `frame_cmd_queue`

## Requirements
- R1: While `cmdEnable` is low, a `wordWrite` strobe has no effect: `wordCount` stays 0 and `pendingCount` stays 0.
- R2: Accepted words fill one command in fixed order: word 0 is the luma address (`startYAddr`), word 1 is the first chroma address (`startUAddr`), word 2 is the second chroma address (`startVAddr`) and word 3 is the destination (`startOutAddr`).
- R3: `wordCount` advances by one per accepted word and wraps from 3 to 0. A command enters the queue only on its fourth word, in the cycle after that word is written.
- R4: `pendingCount` never exceeds 2. `cmdFull` is high exactly when it equals 2, and `wordCount` is then 0.
- R5: A word written while enabled, with `cmdFull` high and no pop in the same cycle, is dropped. `wordCount` and the queue do not change, and `overflow` becomes 1 and stays 1.
- R6: The head command is removed when `startValid` and `startReady` are both high. A write in that same cycle is accepted even when `cmdFull` is high.
- R7: `startValid` is high only when enabled, the queue is non-empty and `engineBusy` is low. `engineBusy` rises after a handshake and falls after `frameDone`.
- R8: `frameDone` while `engineBusy` is high sets `endStatus` in the next cycle. `endClear` clears `endStatus`, but setting wins when both happen in the same cycle. `frameDone` while idle has no effect.
- R9: `irq` equals `endStatus` AND `irqEnable` in every cycle.
- R10: A cycle with `cmdEnable` low empties the queue, zeroes `wordCount` and clears `overflow`. It leaves a frame that is already in flight running.
- R11: After reset, every counter and flag is 0 and `startValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdEnable | input | 1 | Master enable for the command port |
| wordWrite | input | 1 | Command-word write strobe |
| wordData | input | AW | Command word |
| endClear | input | 1 | Write-one-to-clear strobe for endStatus |
| irqEnable | input | 1 | Interrupt mask |
| startReady | input | 1 | Engine accepts the presented command |
| frameDone | input | 1 | Engine finished its current frame |
| startValid | output | 1 | A command is presented to the engine |
| startYAddr | output | AW | Luma source address of the head command |
| startUAddr | output | AW | First chroma source address |
| startVAddr | output | AW | Second chroma source address |
| startOutAddr | output | AW | Destination address |
| engineBusy | output | 1 | A frame is in flight |
| cmdFull | output | 1 | Both queue slots occupied |
| wordCount | output | 2 | Words gathered for the partial command |
| pendingCount | output | clog2(QDEPTH+1) | Queued commands |
| endStatus | output | 1 | Sticky frame-finished flag |
| overflow | output | 1 | Sticky dropped-write flag |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions treat `frameDone` as meaningful only while a frame is in flight; pulses in the idle state are expected to be ignored. They place no constraint on `startReady`, which may be held high or toggled freely. The stimulus stresses these points directly. It issues `frameDone` pulses while idle, toggles `startReady` at random, and writes into a full queue, both with and without a simultaneous pop. It also drops `cmdEnable` mid-command and while a frame is running.

// File: rtl/fcq_pkg.sv
package fcq_pkg;

  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic       stageWr;   // capture wordData into staging slot wordSel
    logic [1:0] wordSel;   // position of the accepted word in its command
    logic       push;      // fourth word: write full command into queue
    logic       pop;       // handshake: retire the head slot
    logic       flush;     // enable low: drop all queued commands
  } dpStrobeT;

endpackage

// File: rtl/fcq_datapath.sv
module fcq_datapath
  import fcq_pkg::*;
#(
  parameter int AW     = 32,
  parameter int QDEPTH = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobeT      strobe,
  input  logic [AW-1:0] wordData,
  output logic [AW-1:0] headY,
  output logic [AW-1:0] headU,
  output logic [AW-1:0] headV,
  output logic [AW-1:0] headOut
);

  localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int ENT_W = 4 * AW;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(QDEPTH - 1);

  logic [AW-1:0]    stage [3];
  logic [ENT_W-1:0] slot  [QDEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  // Staging for the first three words of a command
  generate
    for (genvar s = 0; s < 3; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage[s] <= '0;
        end else if (strobe.stageWr && strobe.wordSel == 2'(s)) begin
          stage[s] <= wordData;
        end
      end
    end
  endgenerate

  // Queue slots, written on the fourth word
  generate
    for (genvar q = 0; q < QDEPTH; q++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slot[q] <= '0;
        end else if (strobe.push && wrPtr == PTR_W'(q)) begin
          slot[q] <= {stage[0], stage[1], stage[2], wordData};
        end
      end
    end
  endgenerate

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_comb begin
    {headY, headU, headV, headOut} = slot[rdPtr];
  end

  // Push and flush are never issued together by the control side
  AST_PUSH_NOT_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.push && strobe.flush)); // R10

  // The staging write and the queue push never both fire in one cycle
  AST_STAGE_XOR_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.push && strobe.stageWr)); // R3

endmodule

// File: rtl/fcq_ctrl.sv
module fcq_ctrl
  import fcq_pkg::*;
#(
  parameter int QDEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdEnable,
  input  logic                       wordWrite,
  input  logic                       endClear,
  input  logic                       irqEnable,
  input  logic                       startReady,
  input  logic                       frameDone,
  output dpStrobeT                   strobe,
  output logic                       startValid,
  output logic                       engineBusy,
  output logic                       cmdFull,
  output logic [1:0]                 wordCount,
  output logic [$clog2(QDEPTH+1)-1:0] pendingCount,
  output logic                       endStatus,
  output logic                       overflow,
  output logic                       irq
);

  localparam int CNT_W = $clog2(QDEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(QDEPTH);

  logic [CNT_W-1:0] count;
  logic [1:0]       wordCnt;
  logic             busy, endFlag, ovfFlag;
  logic             popNow, wrAccept, wrDrop, lastWord;

  assign cmdFull    = (count == FULL_CNT);
  assign startValid = cmdEnable && (count != '0) && !busy;
  assign popNow     = startValid && startReady;
  assign wrAccept   = cmdEnable && wordWrite && (!cmdFull || popNow);
  assign wrDrop     = cmdEnable && wordWrite && cmdFull && !popNow;
  assign lastWord   = wrAccept && (wordCnt == 2'd3);

  always_comb begin
    strobe.stageWr = wrAccept && !lastWord;
    strobe.wordSel = wordCnt;
    strobe.push    = lastWord;
    strobe.pop     = popNow;
    strobe.flush   = !cmdEnable;
  end

  // Word gathering counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          wordCnt <= '0;
    else if (!cmdEnable) wordCnt <= '0;
    else if (wrAccept)  wordCnt <= wordCnt + 2'd1;
  end

  // Queue occupancy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           count <= '0;
    else if (!cmdEnable) count <= '0;
    else begin
      unique case ({lastWord, popNow})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // One frame in flight
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busy <= 1'b0;
    else if (popNow)    busy <= 1'b1;
    else if (frameDone) busy <= 1'b0;
  end

  // End status: set on completion, write-one-to-clear, set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   endFlag <= 1'b0;
    else if (busy && frameDone)  endFlag <= 1'b1;
    else if (endClear)           endFlag <= 1'b0;
  end

  // Sticky overflow, cleared by dropping the enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ovfFlag <= 1'b0;
    else if (!cmdEnable) ovfFlag <= 1'b0;
    else if (wrDrop)     ovfFlag <= 1'b1;
  end

  assign engineBusy   = busy;
  assign wordCount    = wordCnt;
  assign pendingCount = count;
  assign endStatus    = endFlag;
  assign overflow     = ovfFlag;
  assign irq          = endFlag && irqEnable;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT); // R4

  AST_FULL_NO_PARTIAL: assert property (@(posedge clk) disable iff (!rstN)
    cmdFull |-> wordCnt == 2'd0); // R4

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    startValid |-> !engineBusy); // R7

  AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEnable && wordWrite && cmdFull && !(startValid && startReady))
      |=> ($stable(wordCnt) && overflow)); // R5

  AST_DISABLE_FLUSHES: assert property (@(posedge clk) disable iff (!rstN)
    !cmdEnable |=> (pendingCount == '0 && wordCnt == 2'd0 && !overflow)); // R10

  AST_END_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (engineBusy && frameDone) |=> endStatus); // R8

  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!engineBusy && !endStatus && !(startValid && startReady)) |=> !engineBusy && !endStatus); // R8

  AST_HANDSHAKE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && startReady) |=> engineBusy); // R6

endmodule

// File: rtl/frame_cmd_queue.sv
module frame_cmd_queue
  import fcq_pkg::*;
#(
  parameter int AW     = 32,
  parameter int QDEPTH = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdEnable,
  input  logic                        wordWrite,
  input  logic [AW-1:0]               wordData,
  input  logic                        endClear,
  input  logic                        irqEnable,
  input  logic                        startReady,
  input  logic                        frameDone,
  output logic                        startValid,
  output logic [AW-1:0]               startYAddr,
  output logic [AW-1:0]               startUAddr,
  output logic [AW-1:0]               startVAddr,
  output logic [AW-1:0]               startOutAddr,
  output logic                        engineBusy,
  output logic                        cmdFull,
  output logic [1:0]                  wordCount,
  output logic [$clog2(QDEPTH+1)-1:0] pendingCount,
  output logic                        endStatus,
  output logic                        overflow,
  output logic                        irq
);

  dpStrobeT strobe;

  fcq_ctrl #(.QDEPTH(QDEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdEnable(cmdEnable), .wordWrite(wordWrite),
    .endClear(endClear), .irqEnable(irqEnable), .startReady(startReady),
    .frameDone(frameDone), .strobe(strobe), .startValid(startValid),
    .engineBusy(engineBusy), .cmdFull(cmdFull), .wordCount(wordCount),
    .pendingCount(pendingCount), .endStatus(endStatus), .overflow(overflow),
    .irq(irq)
  );

  fcq_datapath #(.AW(AW), .QDEPTH(QDEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordData(wordData),
    .headY(startYAddr), .headU(startUAddr), .headV(startVAddr),
    .headOut(startOutAddr)
  );

  // Interrupt always tracks flag and mask
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rstN)
    irq == (endStatus && irqEnable)); // R9

endmodule

// File: tb/frame_cmd_queue_tb_top.sv
module frame_cmd_queue_tb_top;

  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdEnable = 0, wordWrite = 0, endClear = 0, irqEnable = 0;
  logic startReady = 0, frameDone = 0;
  logic [AW-1:0] wordData = '0;

  logic startValid, engineBusy, cmdFull, endStatus, overflow, irq;
  logic [AW-1:0] startYAddr, startUAddr, startVAddr, startOutAddr;
  logic [1:0] wordCount, pendingCount;

  always #5 clk = ~clk;

  frame_cmd_queue #(.AW(AW), .QDEPTH(2)) dut_i (
    .clk(clk), .rstN(rstN), .cmdEnable(cmdEnable), .wordWrite(wordWrite),
    .wordData(wordData), .endClear(endClear), .irqEnable(irqEnable),
    .startReady(startReady), .frameDone(frameDone), .startValid(startValid),
    .startYAddr(startYAddr), .startUAddr(startUAddr), .startVAddr(startVAddr),
    .startOutAddr(startOutAddr), .engineBusy(engineBusy), .cmdFull(cmdFull),
    .wordCount(wordCount), .pendingCount(pendingCount), .endStatus(endStatus),
    .overflow(overflow), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [4*AW-1:0] mQ[$];
  logic [AW-1:0]   mStage[3];
  int              mWc;
  bit              mBusy, mEnd, mOvf;

  function automatic bit mStartValid();
    return cmdEnable && (mQ.size() != 0) && !mBusy;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mQ.delete(); mWc = 0; mBusy = 0; mEnd = 0; mOvf = 0;
      for (int i = 0; i < 3; i++) mStage[i] = '0;
    end else begin
      bit pop, full, oldBusy;
      pop = mStartValid() && startReady;
      full = (mQ.size() == 2);
      oldBusy = mBusy;
      if (!cmdEnable) begin
        mQ.delete(); mWc = 0; mOvf = 0;
      end else begin
        if (pop) void'(mQ.pop_front());
        if (wordWrite) begin
          if (!full || pop) begin
            if (mWc == 3) mQ.push_back({mStage[0], mStage[1], mStage[2], wordData});
            else mStage[mWc] = wordData;
            mWc = (mWc + 1) % 4;
          end else begin
            mOvf = 1;
          end
        end
      end
      if (pop) mBusy = 1;
      else if (frameDone) mBusy = 0;
      if (oldBusy && frameDone) mEnd = 1;
      else if (endClear) mEnd = 0;
    end
  end

  // ---------------- checking ----------------
  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit sv;
    sv = mStartValid();
    chk("R3 wordCount", wordCount, mWc);
    chk("R4 pendingCount", pendingCount, mQ.size());
    chk("R4 cmdFull", cmdFull, mQ.size() == 2);
    chk("R5 overflow", overflow, mOvf);
    chk("R7 startValid", startValid, sv);
    chk("R7 engineBusy", engineBusy, mBusy);
    chk("R8 endStatus", endStatus, mEnd);
    chk("R9 irq", irq, mEnd && irqEnable);
    if (sv) chk("R2 head fields", {startYAddr, startUAddr, startVAddr, startOutAddr}, mQ[0]);
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    wordWrite = 0; endClear = 0; startReady = 0; frameDone = 0;
  endtask

  task automatic writeWord(input logic [AW-1:0] d);
    wordWrite = 1; wordData = d;
    tick();
    wordWrite = 0;
  endtask

  task automatic writeCmd(input logic [AW-1:0] base);
    for (int k = 0; k < 4; k++) writeWord(base + AW'(k));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tick();
    chk("R11 reset pending", pendingCount, 0);
    chk("R11 reset startValid", startValid, 0);
    chk("R11 reset flags", {endStatus, overflow, engineBusy, irq, wordCount}, 0);

    // R1: writes while disabled are ignored
    writeWord(32'hDEAD0000);
    writeWord(32'hDEAD0001);
    chk("R1 wordCount disabled", wordCount, 0);
    chk("R1 pending disabled", pendingCount, 0);

    cmdEnable = 1;
    tick();
    // R2/R3: field order, valid only after four words
    writeWord(32'h1000); writeWord(32'h2000); writeWord(32'h3000);
    chk("R3 not valid after three", startValid, 0);
    writeWord(32'h4000);
    chk("R3 valid after four", startValid, 1);
    chk("R2 order", {startYAddr, startUAddr, startVAddr, startOutAddr},
        {32'h1000, 32'h2000, 32'h3000, 32'h4000});
    // R4/R5: fill, then overflow
    writeCmd(32'h5000);
    chk("R4 full", cmdFull, 1);
    writeWord(32'hBAD0);
    chk("R5 dropped word", wordCount, 0);
    chk("R5 overflow sticky", overflow, 1);
    // R6: pop with same-cycle refill while full
    startReady = 1; wordWrite = 1; wordData = 32'h9000;
    tick();
    idle();
    chk("R6 refill accepted", wordCount, 1);
    chk("R6 popped", pendingCount, 1);
    chk("R7 busy after start", engineBusy, 1);
    // R8/R9: completion, interrupt, clear
    irqEnable = 1; frameDone = 1; tick(); idle();
    chk("R8 end set", endStatus, 1);
    chk("R9 irq", irq, 1);
    endClear = 1; tick(); idle();
    chk("R8 cleared", endStatus, 0);
    // R10: disable flushes
    cmdEnable = 0; tick(); cmdEnable = 1; tick();
    chk("R10 flushed", {pendingCount, wordCount, overflow}, 0);

    // random traffic
    for (int c = 0; c < 6000; c++) begin
      cmdEnable  = ($urandom % 100) < 97;
      wordWrite  = ($urandom % 100) < 55;
      wordData   = $urandom;
      startReady = ($urandom % 100) < 40;
      frameDone  = ($urandom % 100) < 15;
      endClear   = ($urandom % 100) < 10;
      irqEnable  = ($urandom % 100) < 60;
      tick();
    end
    idle();
    tick();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule